// File: doc/BRIEF.md
# Auto-Stepping Address Pointer Pair

This peripheral sits on an 8-bit processor bus and holds two 16-bit address pointers. Software fetches a pointer one byte at a time and uses the result as an indirect address. Reading the high byte through one alias moves the pointer up by one after the access. Reading it through a second alias moves the pointer down by one. A block-copy loop can therefore walk a source and a destination through memory with no index arithmetic of its own.

A 16-bit end register is compared against one selected pointer, which is pointer 1 by default. The first cycle in which they agree produces a one-cycle low pulse on an active-low output. That output is meant to drive the processor's set-overflow input, so the loop can leave on an overflow-flag branch.

Every bus access completes in the single cycle in which `bus_sel` is high. There is no wait state and no back-pressure: the block accepts every access it is offered. Read data is combinational during the access cycle. Any pointer step or register load takes effect at the clock edge that ends that cycle.

Top module: `ptr_step_periph`

## Requirements
- R1: After reset both pointers and the end register are 0x0000 and `so_n` is high. The match that exists at reset does not produce a pulse.
- R2: A read at offset 4*i+1 returns the high byte of pointer i, and the pointer increases by one at the end of that cycle. 0xFFFF steps to 0x0000.
- R3: A read at offset 4*i+3 returns the high byte of pointer i, and the pointer decreases by one at the end of that cycle. 0x0000 steps to 0xFFFF.
- R4: A read at offset 4*i+0 or 4*i+2 returns the low byte of pointer i and leaves the pointer unchanged.
- R5: A write at offset 4*i+0 or 4*i+2 loads bits 7:0 of pointer i, and a write at offset 4*i+1 or 4*i+3 loads bits 15:8. A write never steps the pointer.
- R6: A write at offset 8 loads bits 7:0 of the end register, and a write at offset 9 loads bits 15:8. Reads at offsets 8 to 15 return 0x00 and change nothing.
- R7: `so_n` is low for exactly one cycle, in the cycle after the first cycle in which the compared pointer equals the end register. While the match holds there is no further pulse. Leaving the match and returning to it gives a new pulse.
- R8: An access in the window of one pointer never changes the other pointer.
- R9: `bus_rdata` is 0x00 in any cycle that is not a read (`bus_sel` low, or `bus_we` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid during the access cycle |
| so_n | output | 1 | Active-low one-cycle end-match pulse |

## Verification
A pointer that holds a wrong value, or that stepped the wrong way or on the wrong access, becomes visible at the next read of that pointer's window. That read is usually the very next access, because low-byte reads do not disturb the state. A wrong end value or a wrong match history shows only on `so_n`: as a missing, extra or stretched pulse, exactly one cycle after the compared pointer reaches or leaves the end value. For that reason the bench compares `so_n` against its model in every cycle, not only after accesses.

// File: rtl/ptrc_pkg.sv
package ptrc_pkg;
  localparam int PTR_W  = 16;
  localparam int BYTE_W = 8;

  // per-pointer control strobes produced by the decoder
  typedef struct packed {
    logic ld_lo;
    logic ld_hi;
    logic step_up;
    logic step_dn;
  } ptr_ctl_t;
endpackage

// File: rtl/ptrc_decode.sv
module ptrc_decode
  import ptrc_pkg::*;
#(
  parameter int NPTR = 2,
  parameter int AW   = 4
) (
  input  logic                  sel,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  output ptr_ctl_t [NPTR-1:0]   ctl,
  output logic                  end_ld_lo,
  output logic                  end_ld_hi,
  output logic                  rd_hit,
  output logic [AW-3:0]         rd_idx,
  output logic                  rd_hi
);
  localparam logic [AW-1:0] END_LO = AW'(4 * NPTR);
  localparam logic [AW-1:0] END_HI = AW'(4 * NPTR + 1);
  localparam logic [AW-1:0] WIN_LIMIT = AW'(4 * NPTR);

  logic rd, wr;
  assign rd = sel && !we;
  assign wr = sel && we;

  for (genvar i = 0; i < NPTR; i++) begin : g_win
    localparam logic [AW-3:0] IDX = (AW-2)'(i);
    logic in_win;
    assign in_win           = (addr[AW-1:2] == IDX);
    assign ctl[i].ld_lo     = wr && in_win && !addr[0];
    assign ctl[i].ld_hi     = wr && in_win &&  addr[0];
    assign ctl[i].step_up   = rd && in_win && (addr[1:0] == 2'd1);
    assign ctl[i].step_dn   = rd && in_win && (addr[1:0] == 2'd3);
  end

  assign end_ld_lo = wr && (addr == END_LO);
  assign end_ld_hi = wr && (addr == END_HI);
  assign rd_hit    = rd && (addr < WIN_LIMIT);
  assign rd_idx    = addr[AW-1:2];
  assign rd_hi     = addr[0];
endmodule

// File: rtl/ptrc_counter.sv
module ptrc_counter
  import ptrc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ptr_ctl_t           ctl,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [PTR_W-1:0]   value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (ctl.ld_lo) begin
      value[BYTE_W-1:0] <= wdata;
    end else if (ctl.ld_hi) begin
      value[PTR_W-1:BYTE_W] <= wdata;
    end else if (ctl.step_up) begin
      value <= value + PTR_W'(1);
    end else if (ctl.step_dn) begin
      value <= value - PTR_W'(1);
    end
  end
endmodule

// File: rtl/ptrc_endcmp.sv
module ptrc_endcmp
  import ptrc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_lo,
  input  logic               ld_hi,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic [PTR_W-1:0]   ptr,
  output logic               so_n
);
  logic [PTR_W-1:0] end_q;
  logic             match_c, match_q;

  assign match_c = (ptr == end_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q   <= '0;
      match_q <= 1'b1;   // the reset-state match is not an edge
      so_n    <= 1'b1;
    end else begin
      if (ld_lo) end_q[BYTE_W-1:0]     <= wdata;
      if (ld_hi) end_q[PTR_W-1:BYTE_W] <= wdata;
      match_q <= match_c;
      so_n    <= !(match_c && !match_q);
    end
  end
endmodule

// File: rtl/ptr_step_periph.sv
module ptr_step_periph
  import ptrc_pkg::*;
#(
  parameter int NPTR    = 2,
  parameter int CMP_IDX = 1,
  localparam int AW     = $clog2(4 * NPTR + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [BYTE_W-1:0]  bus_wdata,
  output logic [BYTE_W-1:0]  bus_rdata,
  output logic               so_n
);
  ptr_ctl_t [NPTR-1:0]          ctl;
  logic [NPTR-1:0][PTR_W-1:0]   ptr_q;
  logic                         end_ld_lo, end_ld_hi;
  logic                         rd_hit, rd_hi;
  logic [AW-3:0]                rd_idx;

  ptrc_decode #(.NPTR(NPTR), .AW(AW)) u_dec (
    .sel       (bus_sel),
    .we        (bus_we),
    .addr      (bus_addr),
    .ctl       (ctl),
    .end_ld_lo (end_ld_lo),
    .end_ld_hi (end_ld_hi),
    .rd_hit    (rd_hit),
    .rd_idx    (rd_idx),
    .rd_hi     (rd_hi)
  );

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    ptrc_counter u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl   (ctl[i]),
      .wdata (bus_wdata),
      .value (ptr_q[i])
    );
  end

  ptrc_endcmp u_cmp (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_lo (end_ld_lo),
    .ld_hi (end_ld_hi),
    .wdata (bus_wdata),
    .ptr   (ptr_q[CMP_IDX]),
    .so_n  (so_n)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NPTR; i++) begin
      if (rd_hit && (rd_idx == (AW-2)'(i))) begin
        bus_rdata = rd_hi ? ptr_q[i][PTR_W-1:BYTE_W] : ptr_q[i][BYTE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ptrc_chk.sv
module ptrc_chk #(
  parameter int NPTR = 2,
  parameter int AW   = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_sel,
  input logic                  bus_we,
  input logic [AW-1:0]         bus_addr,
  input logic [7:0]            bus_wdata,
  input logic [7:0]            bus_rdata,
  input logic                  so_n,
  input logic [NPTR-1:0][15:0] ptr_q
);
  logic rd0, wr0;
  assign rd0 = bus_sel && !bus_we && (bus_addr[AW-1:2] == '0);
  assign wr0 = bus_sel &&  bus_we && (bus_addr[AW-1:2] == '0);

  p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && bus_addr[1:0] == 2'd1) |=> ptr_q[0] == $past(ptr_q[0]) + 16'd1);

  p_dn_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && bus_addr[1:0] == 2'd3) |=> ptr_q[0] == $past(ptr_q[0]) - 16'd1);

  p_low_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !bus_addr[0]) |=> $stable(ptr_q));

  p_write_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && !bus_addr[0]) |=>
      (ptr_q[0][7:0] == $past(bus_wdata)) && (ptr_q[0][15:8] == $past(ptr_q[0][15:8])));

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !so_n |=> so_n);

  p_other_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr[AW-1:2] == '0) |=> $stable(ptr_q[NPTR-1]));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |-> bus_rdata == 8'h00);
endmodule

bind ptr_step_periph ptrc_chk #(.NPTR(NPTR), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .so_n      (so_n),
  .ptr_q     (ptr_q)
);

// File: tb/sim_ptr_step_periph.sv
`timescale 1ns/1ps
module sim_ptr_step_periph;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       so_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [15:0] mp [2];
  logic [15:0] mend;
  bit          mq, exp_so;

  always #4 clk = ~clk;

  ptr_step_periph u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .so_n(so_n)
  );

  function automatic logic [7:0] model_read(bit s, bit w, logic [3:0] a);
    if (s && !w && a < 4'd8) return a[0] ? mp[a[2]][15:8] : mp[a[2]][7:0];
    return 8'h00;
  endfunction

  function automatic string auto_tag(bit s, bit w, logic [3:0] a);
    if (!s || w) return "R9";
    if (a >= 4'd8) return "R6";
    if (a[1:0] == 2'd1) return "R2";
    if (a[1:0] == 2'd3) return "R3";
    return "R4";
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic do_op(bit s, bit w, logic [3:0] a, logic [7:0] d, string tag = "");
    bit m, nso;
    @(negedge clk);
    check("R7 so_n", {15'd0, so_n}, {15'd0, exp_so});
    sel = s; we = w; addr = a; wdata = d;
    #1;
    check(tag == "" ? auto_tag(s, w, a) : tag, {8'd0, rdata}, {8'd0, model_read(s, w, a)});
    m   = (mp[1] == mend);
    nso = !(m && !mq);
    mq  = m;
    if (s && w) begin
      if (a < 4'd8) begin
        if (a[0]) mp[a[2]][15:8] = d; else mp[a[2]][7:0] = d;
      end else if (a == 4'd8) mend[7:0] = d;
      else if (a == 4'd9) mend[15:8] = d;
    end else if (s && a < 4'd8) begin
      if (a[1:0] == 2'd1) mp[a[2]] = mp[a[2]] + 16'd1;
      if (a[1:0] == 2'd3) mp[a[2]] = mp[a[2]] - 16'd1;
    end
    @(posedge clk);
    exp_so = nso;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) do_op(1'b0, 1'b0, 4'd0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [3:0] a;
    mp[0] = 16'h0000; mp[1] = 16'h0000; mend = 16'h0000;
    mq = 1'b1; exp_so = 1'b1;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset state, no pulse for the reset-time match
    idle(3);
    do_op(1, 0, 4'd0, 8'h00, "R1");
    do_op(1, 0, 4'd4, 8'h00, "R1");
    @(negedge clk); check("R1 so_n high", {15'd0, so_n}, 16'd1);

    // R5: byte loads through both aliases, no step
    do_op(1, 1, 4'd0, 8'h34);
    do_op(1, 1, 4'd1, 8'h12);
    do_op(1, 0, 4'd0, 8'h00, "R5");
    do_op(1, 1, 4'd2, 8'h78);
    do_op(1, 1, 4'd3, 8'h56);
    do_op(1, 0, 4'd2, 8'h00, "R5");
    do_op(1, 0, 4'd3, 8'h00, "R5");   // high byte 56, then steps down
    do_op(1, 0, 4'd0, 8'h00, "R5");   // 77

    // R2: wrap on increment
    do_op(1, 1, 4'd0, 8'hFF);
    do_op(1, 1, 4'd1, 8'hFF);
    do_op(1, 0, 4'd1, 8'h00, "R2");
    do_op(1, 0, 4'd0, 8'h00, "R2");
    do_op(1, 0, 4'd1, 8'h00, "R2");

    // R3: wrap on decrement
    do_op(1, 1, 4'd0, 8'h00);
    do_op(1, 1, 4'd1, 8'h00);
    do_op(1, 0, 4'd3, 8'h00, "R3");
    do_op(1, 0, 4'd0, 8'h00, "R3");
    do_op(1, 0, 4'd1, 8'h00, "R3");

    // R8: pointer 1 untouched by all of the above
    do_op(1, 0, 4'd4, 8'h00, "R8");
    do_op(1, 0, 4'd6, 8'h00, "R8");

    // R6: end register write-only, reads above the windows return zero
    do_op(1, 1, 4'd8, 8'h02);
    do_op(1, 1, 4'd9, 8'h01);
    do_op(1, 0, 4'd8, 8'h00, "R6");
    do_op(1, 0, 4'd9, 8'h00, "R6");
    do_op(1, 0, 4'd15, 8'h00, "R6");

    // R7: reach end 0x0102 from 0x0100, hold, leave, re-enter
    do_op(1, 1, 4'd4, 8'h00);
    do_op(1, 1, 4'd5, 8'h01);
    do_op(1, 0, 4'd5, 8'h00);
    do_op(1, 0, 4'd5, 8'h00);
    idle(4);
    do_op(1, 0, 4'd7, 8'h00);
    do_op(1, 0, 4'd5, 8'h00);
    idle(3);

    // random mix, values biased to hit wraps and matches
    for (int i = 0; i < 6000; i++) begin
      case ($urandom % 4)
        0: d = 8'h00;
        1: d = 8'hFF;
        2: d = 8'h01;
        default: d = 8'($urandom);
      endcase
      a = 4'($urandom);
      if (($urandom % 8) == 0) a = {3'b010, 1'($urandom)};
      do_op(1'($urandom % 5 != 0), 1'($urandom % 3 == 0), a, d);
    end
    idle(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule